// File: doc/BRIEF.md
# Fractional-Rate Pulse-Width Modulator

This block produces a pulse-width modulated output from a fixed reference clock (19.2 MHz in the intended system). The period is not made by an integer divider. A fixed-point increment, with an integer part and a fractional part, is added into a phase accumulator on every enabled clock. The upper bits of the accumulator act as the period counter. The output is high while that counter is below an on-time value. The output frequency is about f_clk × increment / 2^INT_W, and the duty cycle is about on_time / 2^INT_W. With the default 8-bit counter, one duty step is 1/256 of the period.

Software writes a configuration word that carries the increment, and an on-time value. It then pulses the update strobe. The new pair is held in a staging register and becomes active only when the counter wraps, so a period is never cut short or stretched in the middle. While the block is disabled, a pending pair takes effect on the next clock. Disabling the block clears the accumulator and forces the output low.

Top module: `pwm_frac_gen`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the staging register, the pending flag and the active increment and on-time. The output is low during reset, and the block comes out of reset with an active on-time of zero.
- R2: On each clock with the block running, the accumulator (INT_W+FRAC_W bits) adds the active increment, modulo 2^(INT_W+FRAC_W). The counter is the upper INT_W bits of the accumulator.
- R3: While running, the output is high exactly when the counter is below the active on-time, compared unsigned.
- R4: The increment is taken from the configuration word. The fraction occupies bits [FIELD_LSB+FRAC_W-1 : FIELD_LSB] and the integer part the INT_W bits directly above it. With the defaults these are bits 29:22 (integer) and 21:8 (fraction). All other bits of the word are ignored.
- R5: An update strobe captures the word and the on-time into staging. While running, the staged pair becomes active only on the clock where the accumulator carries out of its top bit. With an increment of zero the carry never occurs, so the staged pair stays pending.
- R6: While the block is not running, a pending staged pair becomes active on the next clock that has no strobe.
- R7: When enable is sampled low, the accumulator is cleared and the output is low from the next clock. The first enabled clock marks the block as running with the accumulator still at zero, so every run starts at counter value 0.
- R8: An active on-time of zero keeps the output low. The maximum on-time keeps it high for all counter values except the largest.
- R9: A fractional increment gives an average period of 2^(INT_W+FRAC_W)/increment clocks. Over a whole number of accumulator cycles, the count of high clocks equals the number of accumulator values whose counter is below the on-time.
- R10: If several strobes arrive before the staged pair is applied, the last captured pair is the one that becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low clears the accumulator and holds the output low |
| upd | input | 1 | Update strobe, captures cfg_word and cfg_on into staging |
| cfg_word | input | CFG_W | Configuration word carrying the fixed-point increment |
| cfg_on | input | INT_W | On-time, in counter steps |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with INT_W=4, FRAC_W=4, CFG_W=16 and FIELD_LSB=8, so the accumulator has 8 bits and a period lasts only a few to a few dozen clocks. This puts whole accumulator cycles of a fractional increment (2.5, period 6.4 clocks) inside short duty-count windows. It also makes it cheap to reach wrap-timed updates, an increment of zero that never wraps, and the full on-time range from zero to its maximum. Low bits of the configuration word carry junk throughout, so any use of bits outside the increment fields shows up in the output.

// File: rtl/pwm_frac_pkg.sv
package pwm_frac_pkg;

    // Default geometry of the block.
    localparam int DEF_INT_W     = 8;
    localparam int DEF_FRAC_W    = 14;
    localparam int DEF_CFG_W     = 32;
    localparam int DEF_FIELD_LSB = 8;

    // Run state of the phase accumulator.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Width of the accumulator for a given integer and fraction split.
    function automatic int acc_width(input int int_w, input int frac_w);
        return int_w + frac_w;
    endfunction

endpackage

// File: rtl/pwm_cfg_stage.sv
module pwm_cfg_stage
    import pwm_frac_pkg::*;
#(
    parameter int INT_W     = DEF_INT_W,
    parameter int FRAC_W    = DEF_FRAC_W,
    parameter int CFG_W     = DEF_CFG_W,
    parameter int FIELD_LSB = DEF_FIELD_LSB,
    localparam int ACC_W    = acc_width(INT_W, FRAC_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [INT_W-1:0] cfg_on,
    input  logic             apply,
    output logic [ACC_W-1:0] inc_act,
    output logic [INT_W-1:0] on_act,
    output logic             pend
);

    typedef struct packed {
        logic [ACC_W-1:0] inc;
        logic [INT_W-1:0] on;
    } pwm_set_t;

    pwm_set_t stage_q, active_q, captured;

    // Field extraction: fraction at FIELD_LSB, integer part directly above (R4).
    always_comb begin
        captured.inc = cfg_word[FIELD_LSB +: ACC_W];
        captured.on  = cfg_on;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= '0;
            active_q <= '0;
            pend     <= 1'b0;
        end else if (upd) begin
            stage_q <= captured;
            pend    <= 1'b1;
        end else if (pend && apply) begin
            active_q <= stage_q;
            pend     <= 1'b0;
        end
    end

    assign inc_act = active_q.inc;
    assign on_act  = active_q.on;

    // R5: the active pair never changes away from an apply point
    a_r5_hold_midperiod: assert property (@(posedge clk) disable iff (rst)
        (!apply || upd) |=> ($stable(inc_act) && $stable(on_act)));

    // R10: a strobe always leaves a pending pair behind
    a_r10_strobe_pends: assert property (@(posedge clk) disable iff (rst)
        upd |=> pend);

    // R6: a pending pair at an apply point without strobe is consumed
    a_r6_pending_consumed: assert property (@(posedge clk) disable iff (rst)
        (pend && apply && !upd) |=> !pend);

endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc
    import pwm_frac_pkg::*;
#(
    parameter int ACC_W = acc_width(DEF_INT_W, DEF_FRAC_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] inc,
    output logic [ACC_W-1:0] acc,
    output phase_e           phase,
    output logic             wrap
);

    logic [ACC_W:0] sum;

    always_comb begin
        sum  = {1'b0, acc} + {1'b0, inc};
        wrap = (phase == PH_RUN) && sum[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc   <= '0;
            phase <= PH_IDLE;
        end else if (phase == PH_IDLE) begin
            acc   <= '0;
            phase <= PH_RUN;
        end else begin
            acc <= sum[ACC_W-1:0];
        end
    end

    // R7: disabling clears the accumulator and leaves run state
    a_r7_clear_on_disable: assert property (@(posedge clk) disable iff (rst)
        !en |=> (acc == '0 && phase == PH_IDLE));

    // R2: a running clock advances by the increment in force before the edge
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (en && phase == PH_RUN) |=> (acc == ACC_W'($past(acc) + $past(inc))));

    // R7: every run begins from zero
    a_r7_start_zero: assert property (@(posedge clk) disable iff (rst)
        (en && phase == PH_IDLE) |=> (acc == '0 && phase == PH_RUN));

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
    import pwm_frac_pkg::*;
#(
    parameter int INT_W = DEF_INT_W
) (
    input  phase_e           phase,
    input  logic [INT_W-1:0] count,
    input  logic [INT_W-1:0] on_time,
    output logic             level
);

    always_comb begin
        level = (phase == PH_RUN) && (count < on_time);
    end

endmodule

// File: rtl/pwm_frac_gen.sv
module pwm_frac_gen
    import pwm_frac_pkg::*;
#(
    parameter int INT_W     = DEF_INT_W,
    parameter int FRAC_W    = DEF_FRAC_W,
    parameter int CFG_W     = DEF_CFG_W,
    parameter int FIELD_LSB = DEF_FIELD_LSB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             upd,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [INT_W-1:0] cfg_on,
    output logic             pwm_out
);

    localparam int ACC_W = acc_width(INT_W, FRAC_W);

    logic [ACC_W-1:0] inc_act;
    logic [INT_W-1:0] on_act;
    logic             pend;
    logic [ACC_W-1:0] acc;
    phase_e           phase;
    logic             wrap;
    logic             apply;

    // Staged values land at a wrap, or at once while not running.
    assign apply = (phase == PH_IDLE) || wrap;

    pwm_cfg_stage #(
        .INT_W    (INT_W),
        .FRAC_W   (FRAC_W),
        .CFG_W    (CFG_W),
        .FIELD_LSB(FIELD_LSB)
    ) u_stage (
        .clk     (clk),
        .rst     (rst),
        .upd     (upd),
        .cfg_word(cfg_word),
        .cfg_on  (cfg_on),
        .apply   (apply),
        .inc_act (inc_act),
        .on_act  (on_act),
        .pend    (pend)
    );

    pwm_phase_acc #(
        .ACC_W(ACC_W)
    ) u_acc (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .inc  (inc_act),
        .acc  (acc),
        .phase(phase),
        .wrap (wrap)
    );

    pwm_compare #(
        .INT_W(INT_W)
    ) u_cmp (
        .phase  (phase),
        .count  (acc[ACC_W-1 -: INT_W]),
        .on_time(on_act),
        .level  (pwm_out)
    );

    // R7: output is low the clock after enable is seen low
    a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pwm_out);

    // R1: output is low right after a reset clock
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> !pwm_out);

    // R8: zero on-time never drives the output high
    a_r8_zero_on_low: assert property (@(posedge clk) disable iff (rst)
        (on_act == '0) |-> !pwm_out);

    // R5: the active increment moves only at an apply point
    a_r5_inc_at_apply: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(inc_act));

endmodule

// File: tb/sim_pwm_frac_gen.sv
module sim_pwm_frac_gen;

    localparam int  CLK_PERIOD = 10;
    localparam int  T_INT_W    = 4;
    localparam int  T_FRAC_W   = 4;
    localparam int  T_CFG_W    = 16;
    localparam int  T_LSB      = 8;

    logic                clk = 1'b0;
    logic                rst;
    logic                en;
    logic                upd;
    logic [T_CFG_W-1:0]  cfg_word;
    logic [T_INT_W-1:0]  cfg_on;
    logic                pwm_out;

    int    n_run  = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_frac_gen #(
        .INT_W    (T_INT_W),
        .FRAC_W   (T_FRAC_W),
        .CFG_W    (T_CFG_W),
        .FIELD_LSB(T_LSB)
    ) u0 (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .upd     (upd),
        .cfg_word(cfg_word),
        .cfg_on  (cfg_on),
        .pwm_out (pwm_out)
    );

    // Requirement-level model: produces one expected output item per clock.
    bit         exp_q[$];
    logic [7:0] m_acc, m_inc, m_sinc;
    logic [3:0] m_on, m_son;
    logic       m_run, m_pend, m_wr, m_apply;
    logic [8:0] m_sum;

    always @(posedge clk) begin
        if (rst) begin
            m_acc = '0; m_inc = '0; m_sinc = '0;
            m_on = '0;  m_son = '0; m_run = 1'b0; m_pend = 1'b0;
        end else begin
            m_sum   = {1'b0, m_acc} + {1'b0, m_inc};
            m_wr    = m_run && m_sum[8];
            m_apply = !m_run || m_wr;
            if (upd) begin
                m_sinc = cfg_word[15:8];
                m_son  = cfg_on;
                m_pend = 1'b1;
            end else if (m_pend && m_apply) begin
                m_inc  = m_sinc;
                m_on   = m_son;
                m_pend = 1'b0;
            end
            if (!en) begin
                m_acc = '0; m_run = 1'b0;
            end else if (!m_run) begin
                m_acc = '0; m_run = 1'b1;
            end else begin
                m_acc = m_sum[7:0];
            end
        end
        exp_q.push_back(m_run && (m_acc[7:4] < m_on));
    end

    // Monitor: compare each produced output against the queued expectation.
    always @(negedge clk) begin
        bit e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_run++;
            if (pwm_out !== e) begin
                n_fail++;
                $display("FAIL %s scoreboard t=%0t actual=%b expected=%b",
                         cur_req, $time, pwm_out, e);
            end
        end
    end

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_count(input string req, input int n, input int exp);
        int c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c += int'(pwm_out);
        end
        n_run++;
        if (c != exp) begin
            n_fail++;
            $display("FAIL %s high-count actual=%0d expected=%0d", req, c, exp);
        end
    endtask

    task automatic strobe(input logic [3:0] ip, input logic [3:0] fp,
                          input logic [3:0] on);
        @(negedge clk);
        cfg_word = {ip, fp, 8'h5A};
        cfg_on   = on;
        upd      = 1'b1;
        @(negedge clk);
        upd      = 1'b0;
        cfg_word = 16'hFFFF;
        cfg_on   = 4'hF;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; en = 1'b0; upd = 1'b0; cfg_word = '0; cfg_on = '0;
        idle(3);
        chk_bit("R1", pwm_out, 1'b0);
        rst = 1'b0;

        // R6: load while idle, applied at once; R3/R2: integer increment 4, on 8
        cur_req = "R6";
        strobe(4'd4, 4'd0, 4'd8);
        en = 1'b1;
        cur_req = "R3";
        idle(4);
        chk_count("R3", 16, 8);
        cur_req = "R2";
        idle(8);

        // R9: fractional increment 2.5, on 3 -> 6 highs per 32 clocks
        cur_req = "R9";
        strobe(4'd2, 4'd8, 4'd3);
        idle(16);
        chk_count("R9", 32, 6);

        // R10: back-to-back strobes, last one (on 12) wins
        cur_req = "R10";
        @(negedge clk);
        cfg_word = {4'd4, 4'd0, 8'h33}; cfg_on = 4'd1; upd = 1'b1;
        @(negedge clk);
        cfg_word = {4'd4, 4'd0, 8'hC7}; cfg_on = 4'd12;
        @(negedge clk);
        upd = 1'b0; cfg_word = 16'h0F0F;
        idle(16);
        chk_count("R10", 16, 12);

        // R8: maximum on-time, then zero on-time
        cur_req = "R8";
        strobe(4'd1, 4'd0, 4'd15);
        idle(24);
        chk_count("R8", 16, 15);
        strobe(4'd4, 4'd0, 4'd0);
        idle(16);
        chk_count("R8", 16, 0);

        // R5: zero increment stalls the counter; later update stays pending
        cur_req = "R5";
        strobe(4'd0, 4'd0, 4'd8);
        idle(16);
        chk_count("R5", 16, 16);
        strobe(4'd4, 4'd0, 4'd0);
        idle(8);
        chk_count("R5", 16, 16);

        // R7: disable forces low; R6: pending pair lands while idle
        cur_req = "R7";
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk_bit("R7", pwm_out, 1'b0);
        @(negedge clk);
        chk_bit("R7", pwm_out, 1'b0);
        en = 1'b1;
        cur_req = "R6";
        idle(8);
        chk_count("R6", 16, 0);

        // R1: reset mid-run clears the active on-time
        cur_req = "R1";
        strobe(4'd4, 4'd0, 4'd8);
        idle(16);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk_bit("R1", pwm_out, 1'b0);
        rst = 1'b0;
        idle(4);
        chk_count("R1", 16, 0);

        // R4: junk in bits outside the increment fields has no effect
        cur_req = "R4";
        strobe(4'd4, 4'd0, 4'd8);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        idle(4);
        chk_count("R4", 16, 8);

        idle(4);
        finish_run();
    end

endmodule